// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block sequences one analog-to-digital converter that has four multiplexed inputs. Control comes in as register-style fields: a channel code, a single/scan mode bit, a continuous/one-pass bit, a gate for the external trigger, and a conversion-clock divider code. A conversion is started by a software start pulse or, when the gate is open, by an external trigger pulse. The block then steers the input multiplexer, produces a conversion-clock enable from a prescaler, and times each conversion as a fixed number of prescaled ticks.

At the end of each conversion it samples the converter data into the result register of the channel that was converted. It also raises a one-cycle done strobe. A scan always begins at input 0 and climbs to the channel given by the code. A one-pass scan, or a single conversion, ends by dropping the busy (start) bit and setting a sticky end flag. A continuous scan wraps back to input 0 until software clears the start bit. Clearing the start bit aborts at once, and no result is written for the channel that was interrupted.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, busy, end_flag, conv_start, conv_done, conv_clk_en, mux_ch, div_sel and every result register are 0.
- R2: In single mode (cfg_scan=0) only channel cfg_sel is converted. Its result is written, the other results keep their values, busy falls and end_flag rises at the completion edge.
- R3: In scan mode, code cfg_sel=c converts channels 0,1,..,c in ascending order. Result register k sits at res_bus[k*10 +: 10]. With cfg_cont=0 the block stops after channel c and sets end_flag.
- R4: In scan mode with cfg_cont=1, channel c is followed by channel 0 again, busy stays 1, and end_flag is not set by a finished pass.
- R5: ext_trig starts a sequence like sw_start_set when cfg_trg_en=1, and is ignored (busy stays 0) when cfg_trg_en=0.
- R6: Divider code 0,1,2,3 gives one prescaled tick every 32,16,8,4 clocks. A conversion ends CONV_TICKS ticks after it begins, that is CONV_TICKS times the divider clocks after the start edge or after the previous completion edge.
- R7: A cfg_div_wr while busy=1 is ignored: div_sel and the conversion timing are unchanged. While idle the code is taken and shown on div_sel.
- R8: sw_start_clr while busy drops busy at the next edge with no done strobe, no write to the interrupted channel's result and no end_flag.
- R9: end_flag stays 1 until an end_clr pulse. It is then 0 unless a completion sets it on the same edge.
- R10: conv_start is a one-cycle pulse at the start of every conversion, and conv_done is a one-cycle pulse after each completion. mux_ch shows the channel being converted and changes only at start or completion edges.
- R11: conv_clk_en is 0 while idle and pulses once per divider period while busy, which gives exactly CONV_TICKS pulses per conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sel | input | 2 | Channel code (single target or scan upper bound) |
| cfg_scan | input | 1 | 1 = scan mode, 0 = single mode |
| cfg_cont | input | 1 | 1 = continuous scan, 0 = one pass |
| cfg_trg_en | input | 1 | Gate for ext_trig |
| cfg_div_wr | input | 1 | Write strobe for the divider code |
| cfg_div | input | 2 | Divider code written by cfg_div_wr |
| sw_start_set | input | 1 | Software start pulse |
| sw_start_clr | input | 1 | Software clear of the start bit (abort) |
| ext_trig | input | 1 | External trigger pulse |
| end_clr | input | 1 | Clears end_flag |
| adc_data | input | 10 | Converter output sampled at completion |
| busy | output | 1 | Start bit, 1 while a sequence runs |
| mux_ch | output | 2 | Multiplexer channel index |
| conv_clk_en | output | 1 | Prescaled conversion-clock enable |
| conv_start | output | 1 | Conversion request pulse |
| conv_done | output | 1 | Conversion complete pulse |
| end_flag | output | 1 | Sticky end-of-sequence flag |
| div_sel | output | 2 | Divider code in force |
| res_bus | output | 40 | Four 10-bit result registers, channel k at bits k*10+9..k*10 |

## Verification
With a start sampled at edge e0, busy, conv_start and mux_ch are due one cycle later. Conversion i finishes at edge e0 + (i+1)·CONV_TICKS·divider. conv_done, the new result, the next mux_ch and conv_start, and the end_flag and busy changes all become visible in the cycle after that edge. An abort shows in the cycle after the clear is sampled. The bench drives on falling edges and steps exactly CONV_TICKS·divider falling edges per conversion, so every comparison happens in the one cycle where the value is due. It also counts conv_clk_en pulses over that window.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  // clocks per prescaled tick for a divider code
  function automatic int unsigned div_ratio(input int unsigned log2_max, input int unsigned code);
    return 32'd1 << (log2_max - code);
  endfunction
endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler #(
  parameter int DSW          = 2,
  parameter int DIV_LOG2_MAX = 5,
  localparam int PW          = DIV_LOG2_MAX
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run,
  input  logic           div_wr,
  input  logic [DSW-1:0] div_code,
  output logic [DSW-1:0] div_q,
  output logic           tick
);
  import adc_scan_pkg::*;

  logic [PW-1:0] cnt;
  logic [PW-1:0] lim;

  always_comb lim = PW'(div_ratio(DIV_LOG2_MAX, 32'(div_q)) - 1);
  always_comb tick = run && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      cnt   <= '0;
    end else begin
      if (div_wr && !run) div_q <= div_code;
      if (!run || tick) cnt <= '0;
      else              cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int CONV_TICKS = 16,
  localparam int TW        = $clog2(CONV_TICKS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic fin
);
  logic [TW-1:0] cnt;

  always_comb fin = tick && (cnt == TW'(CONV_TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (fin)     cnt <= '0;
    else if (tick)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int NCH      = 4,
  parameter int RW       = 10,
  localparam int CW      = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CW-1:0]     waddr,
  input  logic [RW-1:0]     wdata,
  output logic [NCH*RW-1:0] rdata
);
  logic [RW-1:0] mem [NCH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign rdata[g*RW +: RW] = mem[g];
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int NCH = 4,
  localparam int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] sel,
  input  logic          scan,
  input  logic          cont,
  input  logic          trg_en,
  input  logic          start_set,
  input  logic          start_clr,
  input  logic          trig,
  input  logic          flag_clr,
  input  logic          conv_fin,
  output logic          start_q,
  output logic [CW-1:0] ch_q,
  output logic          conv_start_q,
  output logic          conv_done_q,
  output logic          end_q,
  output logic          wr_en
);
  logic          last_scan;
  logic [CW-1:0] last_q;
  logic          scan_q;
  logic          cont_q;
  logic          start_evt;

  always_comb begin
    start_evt = !start_q && !start_clr && (start_set || (trg_en && trig));
    wr_en     = start_q && conv_fin && !start_clr;
    last_scan = !scan_q || (ch_q == last_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q      <= 1'b0;
      ch_q         <= '0;
      last_q       <= '0;
      scan_q       <= 1'b0;
      cont_q       <= 1'b0;
      conv_start_q <= 1'b0;
      conv_done_q  <= 1'b0;
      end_q        <= 1'b0;
    end else begin
      conv_start_q <= 1'b0;
      conv_done_q  <= 1'b0;
      if (flag_clr) end_q <= 1'b0;
      if (start_q && start_clr) begin
        start_q <= 1'b0;
      end else if (start_evt) begin
        start_q      <= 1'b1;
        last_q       <= sel;
        scan_q       <= scan;
        cont_q       <= cont;
        ch_q         <= scan ? '0 : sel;
        conv_start_q <= 1'b1;
      end else if (wr_en) begin
        conv_done_q <= 1'b1;
        if (!last_scan) begin
          ch_q         <= ch_q + 1'b1;
          conv_start_q <= 1'b1;
        end else if (scan_q && cont_q) begin
          ch_q         <= '0;
          conv_start_q <= 1'b1;
        end else begin
          start_q <= 1'b0;
          end_q   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int NCH          = 4,
  parameter int RW           = 10,
  parameter int CONV_TICKS   = 16,
  parameter int DSW          = 2,
  parameter int DIV_LOG2_MAX = 5,
  localparam int CW          = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CW-1:0]     cfg_sel,
  input  logic              cfg_scan,
  input  logic              cfg_cont,
  input  logic              cfg_trg_en,
  input  logic              cfg_div_wr,
  input  logic [DSW-1:0]    cfg_div,
  input  logic              sw_start_set,
  input  logic              sw_start_clr,
  input  logic              ext_trig,
  input  logic              end_clr,
  input  logic [RW-1:0]     adc_data,
  output logic              busy,
  output logic [CW-1:0]     mux_ch,
  output logic              conv_clk_en,
  output logic              conv_start,
  output logic              conv_done,
  output logic              end_flag,
  output logic [DSW-1:0]    div_sel,
  output logic [NCH*RW-1:0] res_bus
);
  logic tick;
  logic fin;
  logic wr_en;

  adc_prescaler #(.DSW(DSW), .DIV_LOG2_MAX(DIV_LOG2_MAX)) u_pre (
    .clk(clk), .rst(rst), .run(busy), .div_wr(cfg_div_wr),
    .div_code(cfg_div), .div_q(div_sel), .tick(tick)
  );

  adc_conv_timer #(.CONV_TICKS(CONV_TICKS)) u_tmr (
    .clk(clk), .rst(rst), .run(busy), .tick(tick), .fin(fin)
  );

  adc_seq_ctrl #(.NCH(NCH)) u_ctl (
    .clk(clk), .rst(rst), .sel(cfg_sel), .scan(cfg_scan), .cont(cfg_cont),
    .trg_en(cfg_trg_en), .start_set(sw_start_set), .start_clr(sw_start_clr),
    .trig(ext_trig), .flag_clr(end_clr), .conv_fin(fin),
    .start_q(busy), .ch_q(mux_ch), .conv_start_q(conv_start),
    .conv_done_q(conv_done), .end_q(end_flag), .wr_en(wr_en)
  );

  adc_result_bank #(.NCH(NCH), .RW(RW)) u_res (
    .clk(clk), .rst(rst), .we(wr_en), .waddr(mux_ch),
    .wdata(adc_data), .rdata(res_bus)
  );

  assign conv_clk_en = tick;
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int CW  = 2,
  parameter int DSW = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           cfg_trg_en,
  input logic           sw_start_set,
  input logic           sw_start_clr,
  input logic           ext_trig,
  input logic           end_clr,
  input logic           busy,
  input logic [CW-1:0]  mux_ch,
  input logic           conv_clk_en,
  input logic           conv_start,
  input logic           conv_done,
  input logic           end_flag,
  input logic [DSW-1:0] div_sel
);
  a_r1_reset_idle: assert property (@(posedge clk) rst |=> (!busy && !end_flag && !conv_done));
  a_r5_trig_gated: assert property (@(posedge clk) disable iff (rst)
    (!busy && ext_trig && !cfg_trg_en && !sw_start_set) |=> !busy);
  a_r7_div_hold: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> $stable(div_sel));
  a_r8_abort: assert property (@(posedge clk) disable iff (rst)
    (busy && sw_start_clr) |=> (!busy && !conv_done));
  a_r9_end_sticky: assert property (@(posedge clk) disable iff (rst)
    (end_flag && !end_clr) |=> end_flag);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    conv_done |=> !conv_done);
  a_r10_start_pulse: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);
  a_r10_mux_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !conv_done) |-> $stable(mux_ch));
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !conv_clk_en);
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.CW(CW), .DSW(DSW)) u_chk (
  .clk(clk), .rst(rst), .cfg_trg_en(cfg_trg_en), .sw_start_set(sw_start_set),
  .sw_start_clr(sw_start_clr), .ext_trig(ext_trig), .end_clr(end_clr),
  .busy(busy), .mux_ch(mux_ch), .conv_clk_en(conv_clk_en),
  .conv_start(conv_start), .conv_done(conv_done), .end_flag(end_flag),
  .div_sel(div_sel)
);

// File: tb/tb_adc_scan_seq.sv
module tb_adc_scan_seq;
  localparam int N   = 2;
  localparam int RW  = 10;

  logic clk = 1'b0;
  logic rst;
  logic [1:0] cfg_sel;
  logic cfg_scan, cfg_cont, cfg_trg_en, cfg_div_wr;
  logic [1:0] cfg_div;
  logic sw_start_set, sw_start_clr, ext_trig, end_clr;
  logic [RW-1:0] adc_data;
  logic busy, conv_clk_en, conv_start, conv_done, end_flag;
  logic [1:0] mux_ch, div_sel;
  logic [4*RW-1:0] res_bus;

  logic [RW-1:0] chan_val [4];
  logic [RW-1:0] exp_res  [4];
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  always_comb adc_data = chan_val[mux_ch];

  adc_scan_seq #(.CONV_TICKS(N)) dut (
    .clk(clk), .rst(rst), .cfg_sel(cfg_sel), .cfg_scan(cfg_scan), .cfg_cont(cfg_cont),
    .cfg_trg_en(cfg_trg_en), .cfg_div_wr(cfg_div_wr), .cfg_div(cfg_div),
    .sw_start_set(sw_start_set), .sw_start_clr(sw_start_clr), .ext_trig(ext_trig),
    .end_clr(end_clr), .adc_data(adc_data), .busy(busy), .mux_ch(mux_ch),
    .conv_clk_en(conv_clk_en), .conv_start(conv_start), .conv_done(conv_done),
    .end_flag(end_flag), .div_sel(div_sel), .res_bus(res_bus)
  );

  function automatic int clocks_per_tick(input logic [1:0] code);
    return 32 >> code;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_res(input string req);
    for (int c = 0; c < 4; c++)
      chk(res_bus[c*RW +: RW] == exp_res[c], req, res_bus[c*RW +: RW], exp_res[c]);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic pulse_end_clr();
    end_clr = 1'b1; @(negedge clk); end_clr = 1'b0;
  endtask

  // one full sequence; for continuous scans, 'passes' loops then an abort
  task automatic run_seq(input logic [1:0] sel, input bit scan, input bit cont,
                         input logic [1:0] div, input bit via_trig, input int passes,
                         input bit try_div_wr);
    int d, nconv, ticks, total;
    logic [1:0] ch;
    d = clocks_per_tick(div);
    pulse_end_clr();
    cfg_div = div; cfg_div_wr = 1'b1; @(negedge clk); cfg_div_wr = 1'b0;
    chk(div_sel == div, "R7 idle divider write", div_sel, div);
    for (int c = 0; c < 4; c++) chan_val[c] = RW'($urandom);
    cfg_sel = sel; cfg_scan = scan; cfg_cont = cont;
    if (via_trig) begin cfg_trg_en = 1'b1; ext_trig = 1'b1; end
    else sw_start_set = 1'b1;
    @(negedge clk);
    ext_trig = 1'b0; sw_start_set = 1'b0;
    chk(busy == 1'b1, via_trig ? "R5 trigger starts" : "R3 start busy", busy, 1);
    chk(conv_start == 1'b1, "R10 first conv_start", conv_start, 1);
    nconv = scan ? (sel + 1) : 1;
    total = (scan && cont) ? passes : 1;
    for (int p = 0; p < total; p++) begin
      for (int i = 0; i < nconv; i++) begin
        ch = scan ? 2'(i) : sel;
        chk(mux_ch == ch, "R10 mux channel", mux_ch, ch);
        ticks = 0;
        for (int k = 0; k < N*d; k++) begin
          if (try_div_wr && p == 0 && i == 0 && k == 1) begin cfg_div = ~div; cfg_div_wr = 1'b1; end
          if (try_div_wr && p == 0 && i == 0 && k == 2) cfg_div_wr = 1'b0;
          if (conv_clk_en) ticks++;
          @(negedge clk);
        end
        chk(ticks == N, "R11 ticks per conversion", ticks, N);
        chk(conv_done == 1'b1, "R6 done after N*div clocks", conv_done, 1);
        if (try_div_wr && p == 0 && i == 0) chk(div_sel == div, "R7 busy divider write ignored", div_sel, div);
        exp_res[ch] = chan_val[ch];
        chk_res(scan ? "R3 scan result" : "R2 single result");
        if (i < nconv - 1) begin
          chk(busy && conv_start, "R3 next conversion", {busy, conv_start}, 3);
        end else if (scan && cont) begin
          chk(busy && conv_start && mux_ch == 2'd0, "R4 wrap to channel 0", {busy, conv_start, mux_ch}, 12);
          chk(end_flag == 1'b0, "R4 no end flag", end_flag, 0);
        end else begin
          chk(busy == 1'b0, scan ? "R3 stop after last" : "R2 stop", busy, 0);
          chk(end_flag == 1'b1, scan ? "R3 end flag" : "R2 end flag", end_flag, 1);
        end
      end
    end
    if (scan && cont) begin
      for (int k = 0; k < N*d/2; k++) @(negedge clk);
      chan_val[0] = ~exp_res[0];
      sw_start_clr = 1'b1; @(negedge clk); sw_start_clr = 1'b0;
      chk(busy == 1'b0, "R8 abort busy", busy, 0);
      chk(conv_done == 1'b0, "R8 abort no done", conv_done, 0);
      chk(end_flag == 1'b0, "R8 abort no end", end_flag, 0);
      for (int k = 0; k < N*d; k++) @(negedge clk);
      chk_res("R8 interrupted result kept");
      chk(conv_clk_en == 1'b0, "R11 idle enable low", conv_clk_en, 0);
    end
    cfg_trg_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1;
    cfg_sel = '0; cfg_scan = 0; cfg_cont = 0; cfg_trg_en = 0; cfg_div_wr = 0; cfg_div = '0;
    sw_start_set = 0; sw_start_clr = 0; ext_trig = 0; end_clr = 0;
    for (int c = 0; c < 4; c++) begin chan_val[c] = '0; exp_res[c] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !end_flag && !conv_start && !conv_done && !conv_clk_en, "R1 reset flags",
        {busy, end_flag, conv_start, conv_done, conv_clk_en}, 0);
    chk(mux_ch == 0 && div_sel == 0, "R1 reset mux/div", {mux_ch, div_sel}, 0);
    chk_res("R1 reset results");

    // R5: gated trigger ignored
    cfg_trg_en = 1'b0; ext_trig = 1'b1; @(negedge clk); ext_trig = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R5 gated trigger ignored", busy, 0);
    chk(conv_clk_en == 1'b0, "R11 idle enable low", conv_clk_en, 0);

    // directed corners
    run_seq(2'd2, 1'b0, 1'b0, 2'd3, 1'b0, 1, 1'b0);   // single, divide by 4
    // R9: end flag holds until cleared
    repeat (5) @(negedge clk);
    chk(end_flag == 1'b1, "R9 end flag held", end_flag, 1);
    pulse_end_clr();
    chk(end_flag == 1'b0, "R9 end flag cleared", end_flag, 0);
    run_seq(2'd3, 1'b1, 1'b0, 2'd0, 1'b1, 1, 1'b1);   // full scan, /32, trigger, busy div write
    run_seq(2'd0, 1'b1, 1'b0, 2'd1, 1'b0, 1, 1'b0);   // scan of channel 0 only
    run_seq(2'd2, 1'b1, 1'b1, 2'd2, 1'b0, 2, 1'b0);   // continuous, abort
    run_seq(2'd3, 1'b1, 1'b1, 2'd3, 1'b1, 3, 1'b1);   // continuous via trigger

    // random mix
    for (int r = 0; r < 8; r++) begin
      logic [1:0] s, dv;
      bit sc, cn, tg;
      s  = 2'($urandom); dv = 2'($urandom);
      sc = 1'($urandom); cn = 1'($urandom); tg = 1'($urandom);
      run_seq(s, sc, cn, dv, tg, 1 + ($urandom % 2), 1'($urandom));
    end
    summary();
  end
endmodule